// File: doc/BRIEF.md
# External Interrupt Controller Configuration Bank

This block holds the control and setup registers of an external interrupt controller with eight input lines plus one non-maskable line. Software reaches it through a plain synchronous register port: a word address, 32-bit write data, a write strobe, four byte enables and registered read data. The detection, filtering and debounce datapaths sit outside and take their settings from the block's configuration outputs.

The block has a run bit and a clock-choice bit. Most setup registers may only be changed while the run bit is clear. Writes that arrive while it is set are dropped, and a sticky error flag records each dropped write. The clock-choice bit follows its own rule. A control write that turns the controller on may load it in the same cycle. A control write that turns the controller off leaves it alone.

The block also works out whether the detection logic needs its sampling clock running. It drives that request, and the chosen source, as registered outputs. Each output updates one clock after the register state it depends on.

Register map (word addresses): 0 control (bit0 run, bit1 clock choice), 1 non-maskable setup, 2 event enables, 3 line setup, 4 asynchronous mode, 5 debounce enables, 6 debounce prescaler, 7 status (bit0 error flag).

Top module: `xint_regbank`

## Requirements
- R1: After synchronous reset, every register reads 0, and `clk_req_o` and `clk_sel_o` are 0.
- R2: The event-enable (2), line-setup (3), asynchronous-mode (4), debounce-enable (5) and prescaler (6) registers take bus writes only while the run bit is 0. While the run bit is 1, writes to them leave their contents unchanged.
- R3: A control write (address 0) made while the run bit is 0 loads the run bit from wdata bit0 and the clock-choice bit from wdata bit1. This includes the write that sets the run bit.
- R4: While the run bit is 1, no write changes the clock-choice bit. A control write that clears the run bit keeps the clock-choice bit at its old value.
- R5: The non-maskable setup register (address 1, bits[2:0] sense, bit3 filter) can be written whatever the state of the run bit.
- R6: `clk_req_o` is 1 one cycle after any of these holds, and 0 one cycle after none holds:
  - the non-maskable filter bit is 1, or its sense is 1, 2 or 3;
  - some line has its filter bit set;
  - some line has sense 1 (rise), 2 (fall) or 3 (both) while its asynchronous-mode bit is 0;
  - some line has its debounce-enable bit set.
  Line n uses bits [4n+2:4n] of register 3 as its sense and bit 4n+3 as its filter. Sense 4 is high level and 5 is low level.
- R7: `clk_sel_o` equals the clock-choice bit with one cycle of delay. 1 selects the low-power 32 kHz source and 0 the general clock.
- R8: The status error flag (address 7, bit0) sets when a write to a register named in R2 is dropped. It stays set until a status write with bit0 = 1 clears it. A status write with bit0 = 0 has no effect.
- R9: A write changes only the bytes whose byte enable is 1.
- R10: `bus_rdata` gives, one cycle after an address is presented, the contents the addressed register held in that cycle. Reads succeed whatever the protection state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_be | input | DATA_W/8 | Byte enables |
| bus_rdata | output | DATA_W | Registered read data |
| run_o | output | 1 | Controller run bit |
| nmi_cfg_o | output | 4 | Non-maskable sense and filter |
| evt_en_o | output | N_LINES | Event output enables |
| line_cfg_o | output | 4*N_LINES | Per-line sense and filter |
| async_o | output | N_LINES | Asynchronous mode per line |
| dbn_en_o | output | N_LINES | Debounce enable per line |
| dbn_presc_o | output | PRESC_W | Debounce prescaler |
| clk_req_o | output | 1 | Sampling clock request |
| clk_sel_o | output | 1 | Selected clock source |

## Verification
A protection error shows up on the next read of the affected register. If a protected register took a write it should have dropped, the new value appears one read later. The error flag would also be clear when it should be set.

A wrong clock-choice update shows at `clk_sel_o` one cycle after the faulty write. A fault in the request equation shows at `clk_req_o` one cycle after the setup write that triggers it. The bench sweeps every line, every sense code, the filter bit and the asynchronous bit, and checks each result against an equation computed in the bench.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned SENSE_W    = 3;
  localparam int unsigned LINE_CFG_W = SENSE_W + 1;
  localparam int unsigned N_REGS     = 8;
  localparam int unsigned R_CTRL  = 0;
  localparam int unsigned R_NMI   = 1;
  localparam int unsigned R_EVT   = 2;
  localparam int unsigned R_LINE  = 3;
  localparam int unsigned R_ASYNC = 4;
  localparam int unsigned R_DBEN  = 5;
  localparam int unsigned R_DBPS  = 6;
  localparam int unsigned R_STAT  = 7;

  function automatic logic is_edge_sense(input logic [SENSE_W-1:0] s);
    return (s == SENSE_W'(1)) || (s == SENSE_W'(2)) || (s == SENSE_W'(3));
  endfunction
endpackage

// File: rtl/xint_ctl.sv
module xint_ctl (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_bits,
  input  logic       stat_wr,
  input  logic       err_clr,
  input  logic       prot_drop,
  output logic       run_q,
  output logic       cksel_q,
  output logic       err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cksel_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        // the clock choice only moves while stopped, including the enabling write
        if (!run_q) cksel_q <= ctrl_bits[1];
        run_q <= ctrl_bits[0];
      end
      if (prot_drop)                err_q <= 1'b1;
      else if (stat_wr && err_clr)  err_q <= 1'b0;
    end
  end

  // R4
  cksel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |=> $stable(cksel_q));
  // R3
  enable_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !run_q && ctrl_bits[0]) |=> (run_q && cksel_q == $past(ctrl_bits[1])));
  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    prot_drop |=> err_q);
endmodule

// File: rtl/xint_cfg.sv
module xint_cfg
  import xint_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          run_i,
  input  logic                          wr_nmi,
  input  logic [4:0]                    wr_prot,
  input  logic [DATA_W/8-1:0]           be,
  input  logic [DATA_W-1:0]             wdata,
  output logic                          drop_o,
  output logic [LINE_CFG_W-1:0]         nmi_q,
  output logic [N_LINES-1:0]            evt_q,
  output logic [N_LINES*LINE_CFG_W-1:0] line_q,
  output logic [N_LINES-1:0]            asy_q,
  output logic [N_LINES-1:0]            dbe_q,
  output logic [PRESC_W-1:0]            dbp_q
);
  localparam int unsigned NB     = DATA_W / 8;
  localparam int unsigned LINE_W = N_LINES * LINE_CFG_W;

  logic [DATA_W-1:0] bmask;
  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign bmask[b*8 +: 8] = {8{be[b]}};
  end

  assign drop_o = run_i && (|wr_prot) && (|be);

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q  <= '0;
      evt_q  <= '0;
      line_q <= '0;
      asy_q  <= '0;
      dbe_q  <= '0;
      dbp_q  <= '0;
    end else begin
      if (wr_nmi)
        nmi_q <= (nmi_q & ~bmask[LINE_CFG_W-1:0]) | (wdata[LINE_CFG_W-1:0] & bmask[LINE_CFG_W-1:0]);
      if (!run_i) begin
        if (wr_prot[0]) evt_q  <= (evt_q  & ~bmask[N_LINES-1:0]) | (wdata[N_LINES-1:0] & bmask[N_LINES-1:0]);
        if (wr_prot[1]) line_q <= (line_q & ~bmask[LINE_W-1:0])  | (wdata[LINE_W-1:0]  & bmask[LINE_W-1:0]);
        if (wr_prot[2]) asy_q  <= (asy_q  & ~bmask[N_LINES-1:0]) | (wdata[N_LINES-1:0] & bmask[N_LINES-1:0]);
        if (wr_prot[3]) dbe_q  <= (dbe_q  & ~bmask[N_LINES-1:0]) | (wdata[N_LINES-1:0] & bmask[N_LINES-1:0]);
        if (wr_prot[4]) dbp_q  <= (dbp_q  & ~bmask[PRESC_W-1:0]) | (wdata[PRESC_W-1:0] & bmask[PRESC_W-1:0]);
      end
    end
  end

  // R2
  locked_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    run_i |=> $stable({evt_q, line_q, asy_q, dbe_q, dbp_q}));
  // R5
  nmi_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_nmi && be[0]) |=> (nmi_q == $past(wdata[LINE_CFG_W-1:0])));
endmodule

// File: rtl/xint_clkreq.sv
module xint_clkreq
  import xint_pkg::*;
#(
  parameter int unsigned N_LINES = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LINE_CFG_W-1:0]         nmi_i,
  input  logic [N_LINES*LINE_CFG_W-1:0] line_i,
  input  logic [N_LINES-1:0]            asy_i,
  input  logic [N_LINES-1:0]            dbe_i,
  input  logic                          cksel_i,
  output logic                          clk_req_o,
  output logic                          clk_sel_o
);
  logic [N_LINES-1:0] line_need;
  logic               nmi_need;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign line_need[i] = line_i[i*LINE_CFG_W + SENSE_W]
                        | (is_edge_sense(line_i[i*LINE_CFG_W +: SENSE_W]) & ~asy_i[i])
                        | dbe_i[i];
  end
  assign nmi_need = nmi_i[SENSE_W] | is_edge_sense(nmi_i[SENSE_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_req_o <= 1'b0;
      clk_sel_o <= 1'b0;
    end else begin
      clk_req_o <= nmi_need | (|line_need);
      clk_sel_o <= cksel_i;
    end
  end
endmodule

// File: rtl/xint_regbank.sv
module xint_regbank
  import xint_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_LINES = 8,
  parameter int unsigned PRESC_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic                          bus_we,
  input  logic [DATA_W/8-1:0]           bus_be,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic                          run_o,
  output logic [LINE_CFG_W-1:0]         nmi_cfg_o,
  output logic [N_LINES-1:0]            evt_en_o,
  output logic [N_LINES*LINE_CFG_W-1:0] line_cfg_o,
  output logic [N_LINES-1:0]            async_o,
  output logic [N_LINES-1:0]            dbn_en_o,
  output logic [PRESC_W-1:0]            dbn_presc_o,
  output logic                          clk_req_o,
  output logic                          clk_sel_o
);
  logic [N_REGS-1:0] wsel;
  logic              cksel, err, drop;
  logic [DATA_W-1:0] rd_mux;

  for (genvar r = 0; r < N_REGS; r++) begin : g_dec
    assign wsel[r] = bus_we && (bus_addr == ADDR_W'(r));
  end

  xint_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (wsel[R_CTRL] && bus_be[0]),
    .ctrl_bits (bus_wdata[1:0]),
    .stat_wr   (wsel[R_STAT] && bus_be[0]),
    .err_clr   (bus_wdata[0]),
    .prot_drop (drop),
    .run_q     (run_o),
    .cksel_q   (cksel),
    .err_q     (err)
  );

  xint_cfg #(.N_LINES(N_LINES), .PRESC_W(PRESC_W), .DATA_W(DATA_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run_o),
    .wr_nmi  (wsel[R_NMI]),
    .wr_prot ({wsel[R_DBPS], wsel[R_DBEN], wsel[R_ASYNC], wsel[R_LINE], wsel[R_EVT]}),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .drop_o  (drop),
    .nmi_q   (nmi_cfg_o),
    .evt_q   (evt_en_o),
    .line_q  (line_cfg_o),
    .asy_q   (async_o),
    .dbe_q   (dbn_en_o),
    .dbp_q   (dbn_presc_o)
  );

  xint_clkreq #(.N_LINES(N_LINES)) u_req (
    .clk       (clk),
    .rst       (rst),
    .nmi_i     (nmi_cfg_o),
    .line_i    (line_cfg_o),
    .asy_i     (async_o),
    .dbe_i     (dbn_en_o),
    .cksel_i   (cksel),
    .clk_req_o (clk_req_o),
    .clk_sel_o (clk_sel_o)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(R_CTRL):  rd_mux = DATA_W'({cksel, run_o});
      ADDR_W'(R_NMI):   rd_mux = DATA_W'(nmi_cfg_o);
      ADDR_W'(R_EVT):   rd_mux = DATA_W'(evt_en_o);
      ADDR_W'(R_LINE):  rd_mux = DATA_W'(line_cfg_o);
      ADDR_W'(R_ASYNC): rd_mux = DATA_W'(async_o);
      ADDR_W'(R_DBEN):  rd_mux = DATA_W'(dbn_en_o);
      ADDR_W'(R_DBPS):  rd_mux = DATA_W'(dbn_presc_o);
      ADDR_W'(R_STAT):  rd_mux = DATA_W'(err);
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R6
  dbn_req_chk: assert property (@(posedge clk) disable iff (rst)
    (|dbn_en_o) |=> clk_req_o);
  // R7
  sel_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (clk_sel_o == $past(cksel)));
  // R10
  read_line_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(R_LINE)) |=> (bus_rdata == $past(DATA_W'(line_cfg_o))));
endmodule

// File: tb/xint_regbank_test.sv
module xint_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        run_o, clk_req_o, clk_sel_o;
  logic [3:0]  nmi_cfg_o;
  logic [7:0]  evt_en_o, async_o, dbn_en_o, dbn_presc_o;
  logic [31:0] line_cfg_o;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  xint_regbank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_be(bus_be), .bus_rdata(bus_rdata), .run_o(run_o),
    .nmi_cfg_o(nmi_cfg_o), .evt_en_o(evt_en_o), .line_cfg_o(line_cfg_o),
    .async_o(async_o), .dbn_en_o(dbn_en_o), .dbn_presc_o(dbn_presc_o),
    .clk_req_o(clk_req_o), .clk_sel_o(clk_sel_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 3'(a); bus_we = 1'b0;
    @(posedge clk); #1;
    v = bus_rdata;
  endtask

  task automatic rchk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic req_chk(input string req, input logic exp);
    @(posedge clk); #1;
    chk(req, {31'b0, clk_req_o}, {31'b0, exp});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] cfgv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 8; a++) rchk("R1", a, 32'h0);
    chk("R1 req", {31'b0, clk_req_o}, 32'h0);
    chk("R1 sel", {31'b0, clk_sel_o}, 32'h0);

    // R2 writes accepted while stopped
    wr(2, 32'hA5);        rchk("R2 evt", 2, 32'hA5);
    wr(3, 32'h1234_5678); rchk("R2 line", 3, 32'h1234_5678);
    wr(4, 32'h5A);        rchk("R2 async", 4, 32'h5A);
    wr(5, 32'h81);        rchk("R2 dben", 5, 32'h81);
    wr(6, 32'h3C);        rchk("R2 presc", 6, 32'h3C);
    rchk("R8 no err", 7, 32'h0);

    // R9 byte enables
    wr(3, 32'hFFFF_FFFF, 4'b0100); rchk("R9 byte2", 3, 32'h12FF_5678);
    wr(3, 32'h0000_0000, 4'b1001); rchk("R9 byte0,3", 3, 32'h00FF_5600);
    wr(1, 32'hF, 4'b0000);         rchk("R9 none", 1, 32'h0);

    // R3 enable with clock choice, R7 source output
    wr(0, 32'h3);
    rchk("R3", 0, 32'h3);
    chk("R7 sel", {31'b0, clk_sel_o}, 32'h1);

    // R2 + R8 writes dropped while running
    wr(2, 32'h5A);  rchk("R2 evt lock", 2, 32'hA5);
    wr(3, 32'hFFFF_FFFF); rchk("R2 line lock", 3, 32'h00FF_5600);
    wr(4, 32'hA5);  rchk("R2 async lock", 4, 32'h5A);
    wr(5, 32'h7E);  rchk("R2 dben lock", 5, 32'h81);
    wr(6, 32'hC3);  rchk("R2 presc lock", 6, 32'h3C);
    rchk("R8 set", 7, 32'h1);
    wr(7, 32'h0);   rchk("R8 w0", 7, 32'h1);
    wr(7, 32'h1);   rchk("R8 w1c", 7, 32'h0);

    // R5 non-maskable while running
    wr(1, 32'hB);   rchk("R5", 1, 32'hB);
    rchk("R8 nmi no err", 7, 32'h0);

    // R4 clock choice locked while running, kept on disable
    wr(0, 32'h1);   rchk("R4 run", 0, 32'h3);
    wr(0, 32'h0);   rchk("R4 stop", 0, 32'h2);
    chk("R7 sel held", {31'b0, clk_sel_o}, 32'h1);
    wr(0, 32'h0);   rchk("R3 stopped", 0, 32'h0);
    chk("R7 sel low", {31'b0, clk_sel_o}, 32'h0);

    // R6 clear all sources
    wr(1, 0); wr(3, 0); wr(4, 0); wr(5, 0);
    req_chk("R6 idle", 1'b0);

    // R6 line sweep
    for (int ln = 0; ln < 8; ln++)
      for (int s = 0; s < 8; s++)
        for (int f = 0; f < 2; f++)
          for (int a = 0; a < 2; a++) begin
            cfgv = 32'(((f << 3) | s) << (4 * ln));
            wr(3, cfgv);
            wr(4, 32'(a << ln));
            req_chk("R6 line", (f == 1) || ((s >= 1) && (s <= 3) && (a == 0)));
          end
    wr(3, 0); wr(4, 0);

    // R6 debounce sweep
    for (int ln = 0; ln < 8; ln++) begin
      wr(5, 32'(1 << ln));
      req_chk("R6 dbn", 1'b1);
    end
    wr(5, 0);
    req_chk("R6 dbn off", 1'b0);

    // R6 non-maskable sweep
    for (int v = 0; v < 16; v++) begin
      wr(1, 32'(v));
      req_chk("R6 nmi", ((v & 8) != 0) || ((v & 7) >= 1 && (v & 7) <= 3));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule